// File: doc/BRIEF.md
# Diagnostic Waveform Packet Generator

This block replays a stored test waveform as a framed sample stream so that a downstream datapath can be exercised without live input. It walks a bounded address window of an external waveform memory (asynchronous read), emitting one sample per accepted output beat. Samples are grouped into packets of a programmable length. A programmable number of idle cycles separates consecutive packets. Every packet carries a 64-bit sequence number. A sync flag marks the first packet of each sync period, which spans a programmable number of packets.

Software configures the generator through a small word-indexed register port and starts or stops it with a run bit. The control state machine has three states. ST_IDLE holds all counters cleared and loads the sequence seed; it moves to ST_SEND when run is set. ST_SEND emits one sample each time the output slot is free; after the last sample of a packet it moves to ST_GAP if the gap is non-zero, otherwise it stays in ST_SEND. ST_GAP counts idle cycles and returns to ST_SEND when the count is reached. Clearing run returns any state to ST_IDLE.

Top module: `diag_wavegen`

## Requirements
- R1: After reset the registers read: word 0 control = 0, word 1 samples-per-packet = 256, word 2 packets-per-sync = 781250, word 3 gap = 80, word 4 window start = 0, word 5 window end = 255, word 6 seed low = 0, word 7 seed high = 0; out_valid is low.
- R2: Writes keep only the implemented field bits (control bit 0, 16-bit packet length, 20-bit packets-per-sync, 16-bit gap, 8-bit window bounds, two full 32-bit seed words), and reads return them zero-extended.
- R3: Setting control bit 0 starts a run whose first sample comes from the window start address and carries the seed {word 7, word 6}. Clearing it makes out_valid low on the second clock edge after the write, and it stays low.
- R4: Sample addresses step by one from the window start to the window end, then wrap to the start, continuing across packet boundaries. out_data equals the memory word at that address.
- R5: Each packet has exactly samples-per-packet beats, with out_sop on the first and out_eop on the last; a programmed length of 0 behaves as 1.
- R6: With out_ready held high, exactly gap cycles with out_valid low separate the end-of-packet beat from the next start-of-packet beat, and a gap of 0 gives back-to-back packets.
- R7: out_sync is high only on the start-of-packet beat of packets 0, N, 2N, ... of a run, where N is packets-per-sync (0 behaves as 1).
- R8: out_bsn is constant within a packet and increases by one from each packet to the next, carrying across bit 31.
- R9: While out_valid is high and out_ready is low, all output fields hold, and no sample is skipped or repeated under backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word_addr | input | 3 | Register word index (byte offset / 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the indexed register |
| mem_rd_addr | output | MA_W | Waveform memory read address |
| mem_rd_data | input | DATA_W | Waveform memory data, same-cycle |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | DATA_W | Sample value |
| out_sop | output | 1 | First sample of a packet |
| out_eop | output | 1 | Last sample of a packet |
| out_sync | output | 1 | First packet of a sync period |
| out_bsn | output | 64 | Packet sequence number |

## Verification
A short window that is not a multiple of the packet length, with a three-cycle gap and a three-packet sync period, shows whether address wrap, packet framing, idle spacing and sync placement are independent of one another. Its seed sits just below a 32-bit boundary, so a missing carry in the sequence number is exposed. A periodic ready pattern with zero gap and a different window separates correct stalling from dropped or repeated samples. Zero length and zero period on a single-word window confirm the degenerate encodings, and a stop and restart shows that the seed and window start are reloaded.

// File: rtl/dwg_pkg.sv
package dwg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } dwg_state_e;

    // word indices of the register port (byte offset = 4 * index)
    localparam logic [2:0] IDX_CTRL  = 3'd0;
    localparam logic [2:0] IDX_SPP   = 3'd1;
    localparam logic [2:0] IDX_BPS   = 3'd2;
    localparam logic [2:0] IDX_GAP   = 3'd3;
    localparam logic [2:0] IDX_LO    = 3'd4;
    localparam logic [2:0] IDX_HI    = 3'd5;
    localparam logic [2:0] IDX_SEEDL = 3'd6;
    localparam logic [2:0] IDX_SEEDH = 3'd7;

endpackage

// File: rtl/dwg_regs.sv
module dwg_regs #(
    parameter int CNT_W   = 16,
    parameter int BPS_W   = 20,
    parameter int MA_W    = 8,
    parameter int SPP_RST = 256,
    parameter int BPS_RST = 781250,
    parameter int GAP_RST = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [2:0]        idx,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              run,
    output logic [CNT_W-1:0]  spp,
    output logic [BPS_W-1:0]  bps,
    output logic [CNT_W-1:0]  gap,
    output logic [MA_W-1:0]   lo,
    output logic [MA_W-1:0]   hi,
    output logic [63:0]       seed
);
    import dwg_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            spp  <= CNT_W'(SPP_RST);
            bps  <= BPS_W'(BPS_RST);
            gap  <= CNT_W'(GAP_RST);
            lo   <= '0;
            hi   <= '1;
            seed <= '0;
        end else if (wr) begin
            unique case (idx)
                IDX_CTRL:  run          <= wdata[0];
                IDX_SPP:   spp          <= wdata[CNT_W-1:0];
                IDX_BPS:   bps          <= wdata[BPS_W-1:0];
                IDX_GAP:   gap          <= wdata[CNT_W-1:0];
                IDX_LO:    lo           <= wdata[MA_W-1:0];
                IDX_HI:    hi           <= wdata[MA_W-1:0];
                IDX_SEEDL: seed[31:0]   <= wdata;
                IDX_SEEDH: seed[63:32]  <= wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (idx)
            IDX_CTRL:  rdata = {31'd0, run};
            IDX_SPP:   rdata = 32'(spp);
            IDX_BPS:   rdata = 32'(bps);
            IDX_GAP:   rdata = 32'(gap);
            IDX_LO:    rdata = 32'(lo);
            IDX_HI:    rdata = 32'(hi);
            IDX_SEEDL: rdata = seed[31:0];
            IDX_SEEDH: rdata = seed[63:32];
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/dwg_addr_gen.sv
module dwg_addr_gen #(
    parameter int MA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            step,
    input  logic [MA_W-1:0] lo,
    input  logic [MA_W-1:0] hi,
    output logic [MA_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clr) begin
            addr <= lo;
        end else if (step) begin
            addr <= (addr == hi) ? lo : addr + 1'b1;
        end
    end
endmodule

// File: rtl/dwg_frame_cnt.sv
module dwg_frame_cnt #(
    parameter int CNT_W = 16,
    parameter int BPS_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] spp,
    input  logic [BPS_W-1:0] bps,
    output logic             first_samp,
    output logic             last_samp,
    output logic             first_blk
);
    logic [CNT_W-1:0] samp_q;
    logic [BPS_W-1:0] blk_q;
    logic [CNT_W:0]   samp_nx;
    logic [BPS_W:0]   blk_nx;
    logic             last_blk;

    assign samp_nx    = {1'b0, samp_q} + {{CNT_W{1'b0}}, 1'b1};
    assign blk_nx     = {1'b0, blk_q} + {{BPS_W{1'b0}}, 1'b1};
    // a programmed zero behaves like one
    assign last_samp  = samp_nx >= {1'b0, spp};
    assign last_blk   = blk_nx >= {1'b0, bps};
    assign first_samp = (samp_q == '0);
    assign first_blk  = (blk_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            samp_q <= '0;
            blk_q  <= '0;
        end else if (step) begin
            if (last_samp) begin
                samp_q <= '0;
                blk_q  <= last_blk ? '0 : blk_nx[BPS_W-1:0];
            end else begin
                samp_q <= samp_nx[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/diag_wavegen.sv
module diag_wavegen #(
    parameter int DATA_W  = 16,
    parameter int MA_W    = 8,
    parameter int CNT_W   = 16,
    parameter int BPS_W   = 20,
    parameter int SPP_RST = 256,
    parameter int BPS_RST = 781250,
    parameter int GAP_RST = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_word_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [MA_W-1:0]   mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_sync,
    output logic [63:0]       out_bsn
);
    import dwg_pkg::*;

    localparam int BSN_W = 64;

    logic             run;
    logic [CNT_W-1:0] spp, gap;
    logic [BPS_W-1:0] bps;
    logic [MA_W-1:0]  lo, hi;
    logic [BSN_W-1:0] seed;

    dwg_state_e       st_q, st_d;
    logic [CNT_W-1:0] gap_q;
    logic [CNT_W:0]   gap_nx;
    logic [BSN_W-1:0] bsn_q;
    logic             clr, adv, emit, gap_done, in_gap;
    logic             first_samp, last_samp, first_blk;

    dwg_regs #(
        .CNT_W(CNT_W), .BPS_W(BPS_W), .MA_W(MA_W),
        .SPP_RST(SPP_RST), .BPS_RST(BPS_RST), .GAP_RST(GAP_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_word_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .run(run), .spp(spp),
        .bps(bps), .gap(gap), .lo(lo), .hi(hi), .seed(seed)
    );

    dwg_addr_gen #(.MA_W(MA_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(emit),
        .lo(lo), .hi(hi), .addr(mem_rd_addr)
    );

    dwg_frame_cnt #(.CNT_W(CNT_W), .BPS_W(BPS_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(emit),
        .spp(spp), .bps(bps), .first_samp(first_samp),
        .last_samp(last_samp), .first_blk(first_blk)
    );

    assign clr      = (st_q == ST_IDLE);
    assign in_gap   = (st_q == ST_GAP);
    assign adv      = !out_valid || out_ready;
    assign emit     = (st_q == ST_SEND) && run && adv;
    assign gap_nx   = {1'b0, gap_q} + {{CNT_W{1'b0}}, 1'b1};
    assign gap_done = gap_nx >= {1'b0, gap};

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (run) st_d = ST_SEND;
            ST_SEND: if (emit && last_samp && (gap != '0)) st_d = ST_GAP;
            ST_GAP:  if (gap_done) st_d = ST_SEND;
            default: st_d = ST_IDLE;
        endcase
        if (!run) st_d = ST_IDLE;
    end

    // state register and per-state counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            gap_q <= '0;
            bsn_q <= '0;
        end else begin
            st_q  <= st_d;
            gap_q <= in_gap ? gap_nx[CNT_W-1:0] : '0;
            if (clr) begin
                bsn_q <= seed;
            end else if (emit && last_samp) begin
                bsn_q <= bsn_q + 1'b1;
            end
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_sync  <= 1'b0;
            out_bsn   <= '0;
        end else if (!run) begin
            out_valid <= 1'b0;
        end else if (emit) begin
            out_valid <= 1'b1;
            out_data  <= mem_rd_data;
            out_sop   <= first_samp;
            out_eop   <= last_samp;
            out_sync  <= first_samp && first_blk;
            out_bsn   <= bsn_q;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/dwg_checker.sv
module dwg_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              in_gap,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sop,
    input logic              out_eop,
    input logic              out_sync,
    input logic [63:0]       out_bsn
);
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n || !run)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_bsn)
            && $stable(out_sop) && $stable(out_eop) && $stable(out_sync));

    a_r7_sync_on_sop: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sync |-> out_sop);

    a_r8_bsn_next_packet: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_eop |=>
            !out_valid || (out_sop && out_bsn == $past(out_bsn) + 64'd1));

    a_r8_bsn_same_packet: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_eop |=>
            !out_valid || (!out_sop && out_bsn == $past(out_bsn)));

    a_r3_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !out_valid);

    a_r6_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        in_gap && $past(in_gap) && $past(!out_valid || out_ready) |-> !out_valid);
endmodule

bind diag_wavegen dwg_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .in_gap(in_gap),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_sync(out_sync), .out_bsn(out_bsn)
);

// File: tb/diag_wavegen_bench.sv
module diag_wavegen_bench;
    localparam int DW  = 16;
    localparam int MAW = 8;
    localparam int MAXB = 512;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           reg_wr;
    logic [2:0]     reg_word_addr;
    logic [31:0]    reg_wdata, reg_rdata;
    logic [MAW-1:0] mem_rd_addr;
    logic [DW-1:0]  mem_rd_data;
    logic           out_valid, out_ready, out_sop, out_eop, out_sync;
    logic [DW-1:0]  out_data;
    logic [63:0]    out_bsn;

    always #5 clk = ~clk;

    assign mem_rd_data = {8'hA5, mem_rd_addr};

    diag_wavegen u_diag_wavegen (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word_addr(reg_word_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .out_sync(out_sync), .out_bsn(out_bsn)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [DW-1:0] b_data [MAXB];
    logic          b_sop  [MAXB];
    logic          b_eop  [MAXB];
    logic          b_sync [MAXB];
    logic [63:0]   b_bsn  [MAXB];
    int            b_cyc  [MAXB];
    int            nb;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_word_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_word_addr = a;
        #1;
        chk(reg_rdata == exp, req, $sformatf("read word %0d", a), 128'(reg_rdata), 128'(exp));
    endtask

    task automatic configure(input logic [7:0] lo, input logic [7:0] hi, input logic [15:0] spp,
                             input logic [15:0] gap, input logic [19:0] bps, input logic [63:0] seed);
        wr(3'd0, 32'd0);
        wr(3'd1, 32'(spp));
        wr(3'd2, 32'(bps));
        wr(3'd3, 32'(gap));
        wr(3'd4, 32'(lo));
        wr(3'd5, 32'(hi));
        wr(3'd6, seed[31:0]);
        wr(3'd7, seed[63:32]);
        wr(3'd0, 32'd1);
    endtask

    // gathers n accepted beats; checks R9 hold whenever a beat was stalled
    task automatic collect(input int n, input bit stall);
        logic          held = 1'b0;
        logic [82:0]   hv = '0;
        nb = 0;
        for (int k = 0; k < 4000 && nb < n; k++) begin
            @(negedge clk);
            if (held)
                chk(out_valid && {out_data, out_sop, out_eop, out_sync, out_bsn} == hv,
                    "R9", "stalled beat held", 128'({out_valid, out_data, out_bsn}),
                    128'({1'b1, hv[82:67], hv[63:0]}));
            out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            if (out_valid && out_ready) begin
                b_data[nb] = out_data; b_sop[nb] = out_sop; b_eop[nb] = out_eop;
                b_sync[nb] = out_sync; b_bsn[nb] = out_bsn; b_cyc[nb] = cyc;
                nb++;
            end
            held = out_valid && !out_ready;
            hv   = {out_data, out_sop, out_eop, out_sync, out_bsn};
        end
        out_ready = 1'b1;
        chk(nb == n, "R9", "beats collected", 128'(nb), 128'(n));
    endtask

    task automatic check_beats(input int lo, input int hi, input int spp, input int bps,
                               input int gap, input logic [63:0] seed, input bit idle,
                               input string req);
        int s_eff = (spp == 0) ? 1 : spp;
        int b_eff = (bps == 0) ? 1 : bps;
        for (int i = 0; i < nb; i++) begin
            int          pkt = i / s_eff;
            int          pos = i % s_eff;
            logic [7:0]  a   = 8'(lo + (i % (hi - lo + 1)));
            logic        sop = (pos == 0);
            logic        eop = (pos == s_eff - 1);
            logic        syn = sop && ((pkt % b_eff) == 0);
            logic [82:0] ex  = {8'hA5, a, sop, eop, syn, seed + 64'(pkt)};
            logic [82:0] ac  = {b_data[i], b_sop[i], b_eop[i], b_sync[i], b_bsn[i]};
            chk(ac == ex, req, $sformatf("beat %0d {data,sop,eop,sync,bsn}", i),
                128'(ac), 128'(ex));
            if (idle && i > 0)
                chk(b_cyc[i] - b_cyc[i-1] - 1 == (sop ? gap : 0), "R6",
                    $sformatf("idle cycles before beat %0d", i),
                    128'(b_cyc[i] - b_cyc[i-1] - 1), 128'(sop ? gap : 0));
        end
    endtask

    task automatic t_reset;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 128'(out_valid), 128'(0));
        rd_chk(3'd0, 32'd0, "R1");
        rd_chk(3'd1, 32'd256, "R1");
        rd_chk(3'd2, 32'd781250, "R1");
        rd_chk(3'd3, 32'd80, "R1");
        rd_chk(3'd4, 32'd0, "R1");
        rd_chk(3'd5, 32'd255, "R1");
        rd_chk(3'd6, 32'd0, "R1");
        rd_chk(3'd7, 32'd0, "R1");
    endtask

    task automatic t_fields;
        wr(3'd1, 32'h0001_2345); rd_chk(3'd1, 32'h0000_2345, "R2");
        wr(3'd2, 32'hFFFF_FFFF); rd_chk(3'd2, 32'h000F_FFFF, "R2");
        wr(3'd5, 32'h0000_01FF); rd_chk(3'd5, 32'h0000_00FF, "R2");
        wr(3'd7, 32'hDEAD_BEEF); rd_chk(3'd7, 32'hDEAD_BEEF, "R2");
        wr(3'd0, 32'hFFFF_FFFE); rd_chk(3'd0, 32'h0000_0000, "R2");
    endtask

    task automatic t_framing;
        configure(8'd10, 8'd14, 16'd4, 16'd3, 20'd3, 64'h0000_0000_FFFF_FFFE);
        collect(28, 1'b0);
        check_beats(10, 14, 4, 3, 3, 64'h0000_0000_FFFF_FFFE, 1'b1, "R3 R4 R5 R7 R8");
    endtask

    task automatic t_backpressure;
        configure(8'd200, 8'd203, 16'd3, 16'd0, 20'd2, 64'd5);
        collect(24, 1'b1);
        check_beats(200, 203, 3, 2, 0, 64'd5, 1'b0, "R9 R4 R5 R7 R8");
    endtask

    task automatic t_zero_codes;
        configure(8'd7, 8'd7, 16'd0, 16'd1, 20'd0, 64'h1234);
        collect(6, 1'b0);
        check_beats(7, 7, 0, 0, 1, 64'h1234, 1'b1, "R5 R7");
    endtask

    task automatic t_stop_restart;
        configure(8'd1, 8'd3, 16'd5, 16'd0, 20'd1, 64'h100);
        collect(3, 1'b0);
        wr(3'd0, 32'd0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R3", "valid after stop", 128'(out_valid), 128'(0));
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R3", "valid stays low", 128'(out_valid), 128'(0));
        wr(3'd0, 32'd1);
        collect(2, 1'b0);
        check_beats(1, 3, 5, 1, 0, 64'h100, 1'b0, "R3");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_word_addr = '0; reg_wdata = '0; out_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_framing();
        t_backpressure();
        t_zero_codes();
        t_stop_restart();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule